// File: doc/BRIEF.md
# Transmit Preamble Header Sequencer

This block puts the fields of an outgoing modem burst in order and hands them out one bit at a time. A start pulse latches the configuration and begins a burst. The burst is a run of preamble ones, then a fixed start-of-frame word, then the optional signal, service, length and CRC16 fields that the format select asks for, and then the payload. One bit leaves on every transmit clock enable. A flag beside each bit tells the modulator whether that bit goes out as differential BPSK or as differential QPSK.

The header is always BPSK. The payload may be QPSK in formats 1 to 3. A programmable lead raises a ready level a set number of enables before the first payload bit, so that the payload source has time to prepare.

In constant-rate mode every header bit is held for two enables, so the bit clock never changes speed between the header and the payload.

Payload bits arrive over a valid/ready pair. Ready is high only in a cycle that carries a transmit enable while the block is in its payload phase. A bit moves only when valid and ready are both high. The source must hold valid, data and last steady until that happens. If a payload slot finds valid low, no bit is sent in that slot and the slot is lost. The bit that carries last ends the burst.

Top module: `tx_hdr_seq`

## Requirements
- R1: After reset the block is idle, and tx_valid, tx_qpsk, tx_rdy and pl_ready are all low, whatever bit_en does.
- R2: cfg_mode selects the field order. 0 gives preamble, SFD. 1 gives preamble, SFD, CRC. 2 gives preamble, SFD, length, CRC. 3 gives preamble, SFD, signal, service, length, CRC. The payload follows in every case.
- R3: The preamble is cfg_pre_len ones, and cfg_pre_len must be nonzero at start. The SFD is the 16-bit word 16'hF3A0, sent least significant bit first.
- R4: The signal field (8 bits), the service field (8 bits) and the length field (16 bits) are each sent least significant bit first.
- R5: The CRC register starts at 16'hFFFF and shifts once for every signal, service and length bit, in the order they are sent. The feedback is its top bit XOR the data bit, applied through polynomial 16'h1021. The CRC is sent inverted, most significant bit first. In mode 1 it is therefore 16'h0000.
- R6: Header bits carry tx_qpsk = 0. Payload bits carry tx_qpsk = cfg_qpsk in modes 1 to 3, and 0 in mode 0.
- R7: With cfg_const_rate set, each header bit is sent on two consecutive enables. Payload bits are always sent on one enable each.
- R8: tx_rdy rises after the header enable that leaves cfg_lead header enables still to go. If the whole header is no longer than cfg_lead, it rises right after start. If cfg_lead is 0, it rises after the last header bit. It stays high until the burst ends.
- R9: pl_ready equals bit_en during the payload phase. A slot with pl_valid low gives tx_valid low and consumes nothing.
- R10: After the payload bit that has pl_last set, the block goes idle and tx_rdy falls.
- R11: A start pulse during a burst is ignored. The configuration latched at the first start stays in force.
- R12: Each enable that sends a bit gives a one-cycle tx_valid pulse in the cycle that follows. A cycle without an enable gives no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a burst when idle |
| bit_en | input | 1 | Transmit clock enable, one bit slot |
| cfg_mode | input | 2 | Header format select |
| cfg_qpsk | input | 1 | Payload as QPSK (modes 1 to 3) |
| cfg_const_rate | input | 1 | Hold each header bit for two slots |
| cfg_lead | input | 5 | Ready lead in enables |
| cfg_pre_len | input | PRE_W | Preamble length in bits |
| hdr_signal | input | 8 | Signal field value |
| hdr_service | input | 8 | Service field value |
| hdr_length | input | 16 | Length field value |
| pl_valid | input | 1 | Payload bit offered |
| pl_data | input | 1 | Payload bit |
| pl_last | input | 1 | Offered bit is the last of the burst |
| pl_ready | output | 1 | Payload bit accepted this cycle |
| tx_valid | output | 1 | tx_bit holds a new bit |
| tx_bit | output | 1 | Outgoing bit |
| tx_qpsk | output | 1 | Bit belongs to a QPSK payload |
| tx_rdy | output | 1 | Payload about to start or under way |

## Verification
The assertions assume that cfg_pre_len is nonzero whenever a burst starts. They also assume that the start check looks only at cycles without an enable, so that phase and index are expected to hold still there. The stimulus keeps within these limits. It sweeps preamble lengths of 1 and 4 only. It drives start in the middle of a burst once on an enable cycle and once on an idle cycle, and changes cfg_mode at the same time to show that it has no effect. Payload valid, data and last change only between slots, and they are held steady across the enable edge. This meets the hold rule the handshake imposes on the source.

// File: rtl/tx_hdr_pkg.sv
package tx_hdr_pkg;
  typedef enum logic [2:0] {
    PH_IDLE, PH_PRE, PH_SFD, PH_SIG, PH_SVC, PH_LEN, PH_CRC, PH_DATA
  } phase_t;

  localparam logic [15:0] SFD_WORD = 16'hF3A0;
  localparam logic [15:0] CRC_POLY = 16'h1021;
  localparam logic [15:0] CRC_INIT = 16'hFFFF;

  // field that follows p in format m
  function automatic phase_t next_phase(input phase_t p, input logic [1:0] m);
    phase_t n;
    case (p)
      PH_PRE:  n = PH_SFD;
      PH_SFD:  n = (m == 2'd0) ? PH_DATA :
                   (m == 2'd1) ? PH_CRC  :
                   (m == 2'd2) ? PH_LEN  : PH_SIG;
      PH_SIG:  n = PH_SVC;
      PH_SVC:  n = PH_LEN;
      PH_LEN:  n = PH_CRC;
      PH_CRC:  n = PH_DATA;
      default: n = PH_IDLE;
    endcase
    return n;
  endfunction

  // header bits after the preamble for format m
  function automatic logic [6:0] post_pre_bits(input logic [1:0] m);
    logic [6:0] b;
    b = 7'd16;
    if (m != 2'd0) b = b + 7'd16;
    if (m[1])      b = b + 7'd16;
    if (m == 2'd3) b = b + 7'd16;
    return b;
  endfunction
endpackage

// File: rtl/tx_hdr_crc16.sv
module tx_hdr_crc16
  import tx_hdr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        shift,
  input  logic        din,
  output logic [15:0] crc
);
  logic fb;
  assign fb = crc[15] ^ din;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) crc <= CRC_INIT;
    else if (shift)    crc <= {crc[14:0], 1'b0} ^ (fb ? CRC_POLY : 16'h0000);
  end
endmodule

// File: rtl/tx_hdr_lead.sv
module tx_hdr_lead #(
  parameter int REM_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [REM_W-1:0] total,
  input  logic [4:0]       lead,
  input  logic             step,
  input  logic             done,
  output logic             rdy
);
  logic [REM_W-1:0] rem;
  logic [4:0]       lead_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem    <= '0;
      lead_q <= '0;
      rdy    <= 1'b0;
    end else if (load) begin
      rem    <= total;
      lead_q <= lead;
      rdy    <= (total <= REM_W'(lead));
    end else if (done) begin
      rdy <= 1'b0;
    end else if (step) begin
      rem <= rem - REM_W'(1);
      if (rem <= REM_W'(lead_q) + REM_W'(1)) rdy <= 1'b1;
    end
  end

  // header steps never outnumber the loaded count
  assert_step_in_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> rem != '0);
endmodule

// File: rtl/tx_hdr_seq.sv
module tx_hdr_seq
  import tx_hdr_pkg::*;
#(
  parameter int PRE_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             bit_en,
  input  logic [1:0]       cfg_mode,
  input  logic             cfg_qpsk,
  input  logic             cfg_const_rate,
  input  logic [4:0]       cfg_lead,
  input  logic [PRE_W-1:0] cfg_pre_len,
  input  logic [7:0]       hdr_signal,
  input  logic [7:0]       hdr_service,
  input  logic [15:0]      hdr_length,
  input  logic             pl_valid,
  input  logic             pl_data,
  input  logic             pl_last,
  output logic             pl_ready,
  output logic             tx_valid,
  output logic             tx_bit,
  output logic             tx_qpsk,
  output logic             tx_rdy
);
  localparam int IDX_W = (PRE_W > 4) ? PRE_W : 4;
  localparam int REM_W = ((PRE_W > 6) ? PRE_W : 6) + 2;

  phase_t           phase;
  logic [1:0]       mode_q;
  logic             qpsk_q, const_q, rep;
  logic [PRE_W-1:0] pre_q;
  logic [7:0]       sig_q, svc_q;
  logic [15:0]      len_q;
  logic [IDX_W-1:0] idx, flen;
  logic [15:0]      crc;
  logic             idle, in_hdr, launch, hdr_en, adv, cur_bit, take, fin, crc_shift;
  logic [REM_W-1:0] hbits, total;

  assign idle     = (phase == PH_IDLE);
  assign in_hdr   = !idle && (phase != PH_DATA);
  assign launch   = start && idle;
  assign hdr_en   = bit_en && in_hdr;
  assign adv      = hdr_en && (!const_q || rep);
  assign pl_ready = bit_en && (phase == PH_DATA);
  assign take     = pl_ready && pl_valid;
  assign fin      = take && pl_last;
  assign crc_shift = adv && (phase inside {PH_SIG, PH_SVC, PH_LEN});

  assign hbits = REM_W'(cfg_pre_len) + REM_W'(post_pre_bits(cfg_mode));
  assign total = cfg_const_rate ? {hbits[REM_W-2:0], 1'b0} : hbits;

  always_comb begin
    case (phase)
      PH_PRE:         flen = IDX_W'(pre_q);
      PH_SIG, PH_SVC: flen = IDX_W'(8);
      default:        flen = IDX_W'(16);
    endcase
    case (phase)
      PH_PRE:  cur_bit = 1'b1;
      PH_SFD:  cur_bit = SFD_WORD[idx[3:0]];
      PH_SIG:  cur_bit = sig_q[idx[2:0]];
      PH_SVC:  cur_bit = svc_q[idx[2:0]];
      PH_LEN:  cur_bit = len_q[idx[3:0]];
      PH_CRC:  cur_bit = ~crc[4'd15 - idx[3:0]];
      default: cur_bit = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      idx      <= '0;
      rep      <= 1'b0;
      mode_q   <= '0;
      qpsk_q   <= 1'b0;
      const_q  <= 1'b0;
      pre_q    <= '0;
      sig_q    <= '0;
      svc_q    <= '0;
      len_q    <= '0;
      tx_valid <= 1'b0;
      tx_bit   <= 1'b0;
      tx_qpsk  <= 1'b0;
    end else begin
      tx_valid <= 1'b0;
      if (launch) begin
        phase   <= PH_PRE;
        idx     <= '0;
        rep     <= 1'b0;
        mode_q  <= cfg_mode;
        qpsk_q  <= cfg_qpsk && (cfg_mode != 2'd0);
        const_q <= cfg_const_rate;
        pre_q   <= cfg_pre_len;
        sig_q   <= hdr_signal;
        svc_q   <= hdr_service;
        len_q   <= hdr_length;
      end else if (hdr_en) begin
        tx_valid <= 1'b1;
        tx_bit   <= cur_bit;
        tx_qpsk  <= 1'b0;
        if (const_q && !rep) begin
          rep <= 1'b1;
        end else begin
          rep <= 1'b0;
          if (idx == flen - IDX_W'(1)) begin
            idx   <= '0;
            phase <= next_phase(phase, mode_q);
          end else begin
            idx <= idx + IDX_W'(1);
          end
        end
      end else if (take) begin
        tx_valid <= 1'b1;
        tx_bit   <= pl_data;
        tx_qpsk  <= qpsk_q;
        if (pl_last) phase <= PH_IDLE;
      end
    end
  end

  tx_hdr_crc16 u_crc (
    .clk(clk), .rst_n(rst_n), .clr(launch), .shift(crc_shift), .din(cur_bit), .crc(crc)
  );

  tx_hdr_lead #(.REM_W(REM_W)) u_lead (
    .clk(clk), .rst_n(rst_n), .load(launch), .total(total), .lead(cfg_lead),
    .step(hdr_en), .done(fin), .rdy(tx_rdy)
  );

  assert_prelen_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> cfg_pre_len != '0);
  assert_header_bpsk_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_en |=> tx_valid && !tx_qpsk);
  assert_mode0_bpsk_R6: assert property (@(posedge clk) disable iff (!rst_n)
    take && mode_q == 2'd0 |=> !tx_qpsk);
  assert_rdy_before_payload_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pl_ready |-> tx_rdy);
  assert_idle_after_last_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> idle && !tx_rdy);
  assert_start_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
    start && !idle && !bit_en |=> $stable(phase) && $stable(idx) && $stable(mode_q));
  assert_no_pulse_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> !tx_valid);
endmodule

// File: tb/tx_hdr_seq_test.sv
`timescale 1ns/1ps
module tx_hdr_seq_test;
  logic clk = 1'b0;
  logic rst_n, start, bit_en, cfg_qpsk, cfg_const_rate, pl_valid, pl_data, pl_last;
  logic [1:0] cfg_mode;
  logic [4:0] cfg_lead;
  logic [6:0] cfg_pre_len;
  logic [7:0] hdr_signal, hdr_service;
  logic [15:0] hdr_length;
  logic pl_ready, tx_valid, tx_bit, tx_qpsk, tx_rdy;

  always #2 clk = ~clk;

  tx_hdr_seq #(.PRE_W(7)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .bit_en(bit_en), .cfg_mode(cfg_mode),
    .cfg_qpsk(cfg_qpsk), .cfg_const_rate(cfg_const_rate), .cfg_lead(cfg_lead),
    .cfg_pre_len(cfg_pre_len), .hdr_signal(hdr_signal), .hdr_service(hdr_service),
    .hdr_length(hdr_length), .pl_valid(pl_valid), .pl_data(pl_data), .pl_last(pl_last),
    .pl_ready(pl_ready), .tx_valid(tx_valid), .tx_bit(tx_bit), .tx_qpsk(tx_qpsk),
    .tx_rdy(tx_rdy)
  );

  int checks = 0;
  int errors = 0;
  logic exp_bits [0:255];
  int nbits, pre_end, crc_from;

  task automatic chk(input logic got, input logic exp, input string req, input string what);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s actual %0b expected %0b", req, what, got, exp);
    end
  endtask

  task automatic push(input logic b);
    exp_bits[nbits] = b;
    nbits++;
  endtask

  // expected header from R2..R5
  task automatic build(input int mode, input int pre, input logic [7:0] sg,
                       input logic [7:0] sv, input logic [15:0] ln);
    logic [15:0] c;
    logic fb;
    nbits = 0;
    for (int i = 0; i < pre; i++) push(1'b1);
    for (int i = 0; i < 16; i++) push(16'hF3A0 >> i);
    pre_end = nbits;
    if (mode == 3) begin
      for (int i = 0; i < 8; i++) push(sg[i]);
      for (int i = 0; i < 8; i++) push(sv[i]);
    end
    if (mode >= 2) for (int i = 0; i < 16; i++) push(ln[i]);
    crc_from = nbits;
    if (mode >= 1) begin
      c = 16'hFFFF;
      for (int i = pre_end; i < crc_from; i++) begin
        fb = c[15] ^ exp_bits[i];
        c = {c[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
      end
      for (int i = 15; i >= 0; i--) push(~c[i]);
    end
  endtask

  function automatic string tag_of(input int i, input int mode);
    if (i < pre_end) return "R2 R3";
    if (i < crc_from) return "R2 R4";
    if (mode >= 1) return "R2 R5";
    return "R2";
  endfunction

  task automatic burst(input int mode, input int cst, input int qp, input int lead, input int pre);
    int rep, total, np;
    logic d;
    rep = cst ? 2 : 1;
    np = 5;
    @(negedge clk);
    cfg_mode = 2'(mode); cfg_const_rate = cst[0]; cfg_qpsk = qp[0];
    cfg_lead = 5'(lead); cfg_pre_len = 7'(pre);
    hdr_signal = 8'(mode * 37 + lead);
    hdr_service = 8'(pre * 91 + 5 + cst);
    hdr_length = 16'hA5C3 ^ 16'(lead << 4) ^ 16'(qp);
    build(mode, pre, hdr_signal, hdr_service, hdr_length);
    total = nbits * rep;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(tx_rdy, total <= lead, "R8", "ready right after start");
    chk(tx_valid, 1'b0, "R12", "no pulse on start");
    for (int k = 0; k < total; k++) begin
      bit_en = 1'b1;
      if (k == 2) begin start = 1'b1; cfg_mode = ~cfg_mode; end  // R11 while sending
      @(negedge clk);
      bit_en = 1'b0; start = 1'b0;
      chk(tx_valid, 1'b1, "R12", "header pulse");
      chk(tx_bit, exp_bits[k / rep], (cst != 0) ? "R7" : tag_of(k / rep, mode), "header bit");
      chk(tx_qpsk, 1'b0, "R6", "header is BPSK");
      chk(tx_rdy, (total - k - 1) <= lead, "R8", "ready lead");
      start = (k == 3);  // R11 start in a gap cycle
      @(negedge clk);
      start = 1'b0;
      chk(tx_valid, 1'b0, "R12", "no pulse without enable");
    end
    for (int j = 0; j < np; j++) begin
      if (j == 1) begin
        pl_valid = 1'b0; bit_en = 1'b1;
        #1 chk(pl_ready, 1'b1, "R9", "ready in stalled slot");
        @(negedge clk);
        bit_en = 1'b0;
        chk(tx_valid, 1'b0, "R9", "stalled slot sends nothing");
      end
      d = 1'((j * 3 + lead + mode) >> 1);
      pl_valid = 1'b1; pl_data = d; pl_last = (j == np - 1);
      #1 chk(pl_ready, 1'b0, "R9", "no ready without enable");
      bit_en = 1'b1;
      #1 chk(pl_ready, 1'b1, "R9", "ready with enable");
      @(negedge clk);
      bit_en = 1'b0; pl_valid = 1'b0; pl_last = 1'b0;
      chk(tx_valid, 1'b1, "R9", "payload pulse");
      chk(tx_bit, d, "R9", "payload bit");
      chk(tx_qpsk, (mode != 0) && (qp != 0), "R6", "payload modulation");
      chk(tx_rdy, j != np - 1, "R10", "ready through payload");
    end
    bit_en = 1'b1;
    #1 chk(pl_ready, 1'b0, "R10", "idle after last");
    @(negedge clk);
    bit_en = 1'b0;
    chk(tx_valid, 1'b0, "R10", "no bit when idle");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog run did not finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int leads [4];
    leads = '{0, 1, 7, 31};
    rst_n = 1'b0; start = 1'b0; bit_en = 1'b0; cfg_mode = '0; cfg_qpsk = 1'b0;
    cfg_const_rate = 1'b0; cfg_lead = '0; cfg_pre_len = 7'd1; hdr_signal = '0;
    hdr_service = '0; hdr_length = '0; pl_valid = 1'b0; pl_data = 1'b0; pl_last = 1'b0;
    repeat (3) @(negedge clk);
    chk(tx_valid, 1'b0, "R1", "valid in reset");
    chk(tx_rdy, 1'b0, "R1", "ready level in reset");
    rst_n = 1'b1;
    bit_en = 1'b1;
    #1 chk(pl_ready, 1'b0, "R1", "no payload ready when idle");
    @(negedge clk);
    bit_en = 1'b0;
    chk(tx_valid, 1'b0, "R1", "no bit when idle");
    chk(tx_qpsk, 1'b0, "R1", "qpsk flag idle");
    for (int m = 0; m < 4; m++)
      for (int c = 0; c < 2; c++)
        for (int q = 0; q < 2; q++)
          for (int l = 0; l < 4; l++)
            for (int p = 0; p < 2; p++)
              burst(m, c, q, leads[l], p ? 4 : 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule